// File: doc/BRIEF.md
# Divider-Stepping Bang-Bang Clock Recovery Loop

This block keeps a master-clock division chain in phase with an external synchronization clock. The chain has three stages. The first divides the master clock and the second produces a sample-rate tick. The third produces a comparison clock. The loop has no phase accumulator and no filter. To steer the chain it adds or removes one master-clock count at the input of the first stage. Every later stage inherits that shift.

On each falling edge of the comparison clock, the block samples a synchronized copy of the synchronization clock and picks one direction for the whole next comparison period. A high sample means the chain is late, so the block advances it: steps shorten the period. A low sample means the chain is early, so the block retards it: steps lengthen the period. Steps are applied either on every sample tick or on every second one. Full rate gives a wider capture range. Half rate gives less jitter.

The comparison divider has two settings: a fixed ratio, or a programmable baud-rate ratio. An enable input can switch phase stepping off entirely, and the chain then runs free.

Top module: `divstep_dpll`

## Requirements
- R1: While `rst_n` is low at a clock edge, all counters clear, and `clk_a`, `clk_b`, `comp_clk`, `speed_up` and `slow_down` read 0.
- R2: A comparison period lasts exactly A_DIV*B_DIV*L master cycles when its decision is none. L is the active comparison ratio. The decision is none whenever the synchronized input showed no transition during the elapsed period.
- R3: `sync_in` passes through two synchronizing flops. At each comparison falling edge, a synchronized level of 1 selects advance (`speed_up`=1) and a level of 0 selects retard (`slow_down`=1), provided a transition was seen and stepping is enabled. The sampled level is the value `sync_in` held three master edges before the edge that drops `comp_clk`.
- R4: `speed_up` and `slow_down` are never both 1. They change only in the cycle in which `comp_clk` falls, so every step in one comparison period has the same sense.
- R5: Each step removes one master cycle (advance) or adds one (retard). With `half_rate`=0, one step is taken per sample tick, giving L steps per period. With `half_rate`=1, steps are taken on alternate ticks starting at the comparison edge, giving ceil(L/2) steps. A period therefore lasts A_DIV*B_DIV*L minus that step count when advancing, and plus it when retarding.
- R6: With `comp_sel`=0, L is C_DIV. With `comp_sel`=1, L is `baud_div`, and values 0 and 1 are treated as 2.
- R7: With `shift_en`=0, `sync_in` is ignored: the decision is always none and every period has nominal length.
- R8: For a synchronization period within the capture range, the phase error converges. After settling, the distance from a comparison fall (less the three-cycle sampling lag) to the nearest synchronization rise stays within 16 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Asynchronous synchronization clock |
| shift_en | input | 1 | 1 enables phase stepping; 0 gives free running |
| half_rate | input | 1 | 1 applies steps on alternate sample ticks |
| comp_sel | input | 1 | 0 uses the fixed comparison ratio; 1 uses `baud_div` |
| baud_div | input | BAUD_W | Programmable comparison ratio |
| clk_a | output | 1 | First-stage divided clock |
| clk_b | output | 1 | Sample-rate clock |
| comp_clk | output | 1 | Comparison clock; falls at each decision point |
| speed_up | output | 1 | Current period is being advanced |
| slow_down | output | 1 | Current period is being retarded |

## Verification
The bench uses A_DIV=4, B_DIV=4 and C_DIV=8, giving a 128-cycle comparison period and a capture range of about ±6% at full rate. This lets runs of a hundred periods reach lock for several offsets, with both signs and at both step rates. A 4-bit `baud_div` covers the programmable ratio, including the clamp of small values to 2. Because the bench keeps its own history of every synchronization sample, it checks every decision bit-exactly and every period length to the cycle, in addition to the bound on phase error.

// File: rtl/divstep_pkg.sv
// Shared types for the divider-stepping loop.
package divstep_pkg;
    // Per-period correction sense; also used as a one-cycle step command.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_ADV  = 2'd1,
        STEP_RET  = 2'd2
    } step_e;
endpackage

// File: rtl/divstep_sync.sv
// Two-flop synchronizer with transition detect.
// Assumes async_i is slow relative to clk; edge_o is one cycle wide.
module divstep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic edge_o
);
    logic [2:0] s_q;

    // Shift the raw input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[1:0], async_i};
    end

    assign lvl_o  = s_q[1];
    assign edge_o = s_q[1] ^ s_q[2];
endmodule

// File: rtl/divstep_chain.sv
// Three-stage division chain. Stage A counts master clocks, with a
// step input that adds one count (advance) or holds one count (retard).
// Stage B counts stage-A wraps, and stage C counts stage-B wraps up to L.
// Assumes A_DIV >= 2, B_DIV >= 2, C_DIV >= 2, BAUD_W >= 2.
module divstep_chain
    import divstep_pkg::*;
#(
    parameter int A_DIV  = 4,
    parameter int B_DIV  = 4,
    parameter int C_DIV  = 8,
    parameter int BAUD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step_i,
    input  logic              comp_sel_i,
    input  logic [BAUD_W-1:0] baud_div_i,
    output logic              tick_b_o,
    output logic              comp_evt_o,
    output logic              clk_a_o,
    output logic              clk_b_o,
    output logic              comp_clk_o
);
    localparam int AW       = $clog2(A_DIV + 2);
    localparam int BW       = $clog2(B_DIV);
    localparam int BAUD_MAX = (1 << BAUD_W) - 1;
    localparam int C_MAX    = (C_DIV > BAUD_MAX) ? C_DIV : BAUD_MAX;
    localparam int CW       = $clog2(C_MAX + 1);

    logic [AW-1:0] cnt_a, inc_a, sum_a;
    logic [BW-1:0] cnt_b;
    logic [CW-1:0] cnt_c, lim;
    logic          tick_a, b_last, c_last;

    // Translate the step command into the stage-A increment.
    always_comb begin
        case (step_i)
            STEP_ADV: inc_a = AW'(2);
            STEP_RET: inc_a = '0;
            default:  inc_a = AW'(1);
        endcase
    end

    assign sum_a  = cnt_a + inc_a;
    assign tick_a = (sum_a >= AW'(A_DIV));

    // Stage A: master-clock counter with stepped increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_a <= '0;
        else if (tick_a) cnt_a <= sum_a - AW'(A_DIV);
        else             cnt_a <= sum_a;
    end

    assign b_last   = (cnt_b == BW'(B_DIV - 1));
    assign tick_b_o = tick_a & b_last;

    // Stage B: counts stage-A wraps to make the sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_b <= '0;
        else if (tick_a) cnt_b <= b_last ? '0 : cnt_b + BW'(1);
    end

    // Pick the comparison ratio, clamping small programmed values.
    always_comb begin
        if (comp_sel_i)
            lim = (baud_div_i < BAUD_W'(2)) ? CW'(2) : CW'(baud_div_i);
        else
            lim = CW'(C_DIV);
    end

    assign c_last     = (cnt_c >= lim - CW'(1));
    assign comp_evt_o = tick_b_o & c_last;

    // Stage C: counts sample ticks to make the comparison clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_c <= '0;
        else if (tick_b_o) cnt_c <= c_last ? '0 : cnt_c + CW'(1);
    end

    assign clk_a_o    = (cnt_a >= AW'(A_DIV / 2));
    assign clk_b_o    = (cnt_b >= BW'(B_DIV / 2));
    assign comp_clk_o = (cnt_c >= (lim >> 1));

    // R5
    a_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_a < AW'(A_DIV));

    // R6
    comp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comp_evt_o |-> comp_clk_o ##1 !comp_clk_o);
endmodule

// File: rtl/divstep_phase.sv
// Phase detector. It records whether the synchronized input moved
// during the current comparison period. At the comparison event it
// latches advance, retard or none for the following period.
// Assumes comp_evt_i is a single-cycle pulse.
module divstep_phase
    import divstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift_en_i,
    input  logic  comp_evt_i,
    input  logic  lvl_i,
    input  logic  edge_i,
    output step_e dec_o,
    output step_e dec_next_o
);
    logic  seen_q;
    step_e dec_q;
    logic  seen;

    assign seen = seen_q | edge_i;

    // Decision for the period that begins at this comparison event.
    always_comb begin
        if (!shift_en_i || !seen) dec_next_o = STEP_NONE;
        else if (lvl_i)           dec_next_o = STEP_ADV;
        else                      dec_next_o = STEP_RET;
    end

    // Track transitions within the period; clear at each event.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_q <= 1'b0;
        else if (comp_evt_i) seen_q <= 1'b0;
        else if (edge_i)     seen_q <= 1'b1;
    end

    // Hold one decision for the whole comparison period.
    always_ff @(posedge clk) begin
        if (!rst_n)          dec_q <= STEP_NONE;
        else if (comp_evt_i) dec_q <= dec_next_o;
    end

    assign dec_o = dec_q;

    // R4
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_evt_i |=> $stable(dec_q));

    // R7
    shift_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_evt_i && !shift_en_i) |=> (dec_q == STEP_NONE));

    // R2
    quiet_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_evt_i && !seen_q && !edge_i) |=> (dec_q == STEP_NONE));
endmodule

// File: rtl/divstep_shift.sv
// Step scheduler. On each sample tick it issues a one-cycle step in the
// current period's direction. At half rate it issues only on alternate
// ticks, counted from the comparison event. At the event tick it uses the
// decision being latched, so every step of a period shares one sense.
module divstep_shift
    import divstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  half_i,
    input  logic  opp_i,
    input  logic  comp_evt_i,
    input  step_e dec_i,
    input  step_e dec_next_i,
    output step_e step_o
);
    logic  tog_q;
    logic  gate;
    step_e step_q;

    assign gate = comp_evt_i | ~half_i | ~tog_q;

    // Alternate-tick phase for half-rate stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)          tog_q <= 1'b0;
        else if (comp_evt_i) tog_q <= 1'b1;
        else if (opp_i)      tog_q <= ~tog_q;
    end

    // Register a one-cycle step command for stage A.
    always_ff @(posedge clk) begin
        if (!rst_n)              step_q <= STEP_NONE;
        else if (opp_i && gate)  step_q <= comp_evt_i ? dec_next_i : dec_i;
        else                     step_q <= STEP_NONE;
    end

    assign step_o = step_q;

    // R5
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != STEP_NONE) |=> (step_q == STEP_NONE));

    // R4
    step_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != STEP_NONE) |-> (step_q == dec_i));
endmodule

// File: rtl/divstep_dpll.sv
// Top of the divider-stepping loop. It wires the synchronizer, the phase
// detector, the step scheduler and the division chain together.
// Assumes sync_in is a slow square wave whose rate is near an integer
// multiple of the comparison rate.
module divstep_dpll
    import divstep_pkg::*;
#(
    parameter int A_DIV  = 4,
    parameter int B_DIV  = 4,
    parameter int C_DIV  = 8,
    parameter int BAUD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              shift_en,
    input  logic              half_rate,
    input  logic              comp_sel,
    input  logic [BAUD_W-1:0] baud_div,
    output logic              clk_a,
    output logic              clk_b,
    output logic              comp_clk,
    output logic              speed_up,
    output logic              slow_down
);
    logic  sync_lvl, sync_edge;
    logic  tick_b, comp_evt;
    step_e dec, dec_next, step;

    divstep_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .lvl_o   (sync_lvl),
        .edge_o  (sync_edge)
    );

    divstep_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en),
        .comp_evt_i (comp_evt),
        .lvl_i      (sync_lvl),
        .edge_i     (sync_edge),
        .dec_o      (dec),
        .dec_next_o (dec_next)
    );

    divstep_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_i     (half_rate),
        .opp_i      (tick_b),
        .comp_evt_i (comp_evt),
        .dec_i      (dec),
        .dec_next_i (dec_next),
        .step_o     (step)
    );

    divstep_chain #(
        .A_DIV  (A_DIV),
        .B_DIV  (B_DIV),
        .C_DIV  (C_DIV),
        .BAUD_W (BAUD_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .comp_sel_i (comp_sel),
        .baud_div_i (baud_div),
        .tick_b_o   (tick_b),
        .comp_evt_o (comp_evt),
        .clk_a_o    (clk_a),
        .clk_b_o    (clk_b),
        .comp_clk_o (comp_clk)
    );

    assign speed_up  = (dec == STEP_ADV);
    assign slow_down = (dec == STEP_RET);

    // R4
    one_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({speed_up, slow_down}) && (step == STEP_NONE || step == dec));
endmodule

// File: tb/divstep_dpll_test.sv
module divstep_dpll_test;
    localparam int CLK_PERIOD = 10;
    localparam int A_DIV      = 4;
    localparam int B_DIV      = 4;
    localparam int C_DIV      = 8;
    localparam int BAUD_W     = 4;
    localparam int WATCHDOG   = 190000;
    localparam int ERR_BOUND  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic shift_en = 1'b0;
    logic half_rate = 1'b0;
    logic comp_sel = 1'b0;
    logic [BAUD_W-1:0] baud_div = '0;
    logic clk_a, clk_b, comp_clk, speed_up, slow_down;

    int checks = 0;
    int failures = 0;

    // scenario state
    int  cyc, ps, off, base, steps, settle;
    bit  toggling, locking, have_prev, prev_comp;
    int  f_prev, exp_period;
    logic [1:0] prev_stat;
    logic hist [0:16383];

    divstep_dpll #(.A_DIV(A_DIV), .B_DIV(B_DIV), .C_DIV(C_DIV), .BAUD_W(BAUD_W)) uut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .shift_en(shift_en),
        .half_rate(half_rate), .comp_sel(comp_sel), .baud_div(baud_div),
        .clk_a(clk_a), .clk_b(clk_b), .comp_clk(comp_clk),
        .speed_up(speed_up), .slow_down(slow_down)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Judge one comparison falling edge seen at negedge t.
    task automatic on_fall(input int t);
        logic [1:0] stat;
        int e;
        bit changed;
        int exp_stat;
        stat = {speed_up, slow_down};
        if (have_prev) begin
            // R5 / R2: period length from the previous decision
            chk((t - f_prev) == exp_period, "R5 period", t - f_prev, exp_period);
            changed = 1'b0;
            for (int m = f_prev - 2; m <= t - 3; m++)
                if (hist[m] !== hist[m-1]) changed = 1'b1;
            if (!shift_en || !changed) exp_stat = 0;
            else if (hist[t-3])        exp_stat = 2;
            else                       exp_stat = 1;
            // R3 / R7 / R2: decision from synchronized sample
            chk(int'(stat) == exp_stat, shift_en ? "R3 decision" : "R7 decision",
                int'(stat), exp_stat);
        end
        // R4: never both senses
        chk(stat != 2'b11, "R4 both", int'(stat), 0);
        exp_period = base + (stat == 2'b01 ? steps : 0) - (stat == 2'b10 ? steps : 0);
        if (locking && t >= settle) begin
            e = (t - 3 + off) % ps;
            if (e >= ps / 2) e = e - ps;
            // R8: bounded phase error after settling
            chk(e <= ERR_BOUND && e >= -ERR_BOUND, "R8 phase", e, 0);
        end
        f_prev = t;
        have_prev = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (prev_comp && !comp_clk) on_fall(cyc);
        else if (rst_n && ({speed_up, slow_down} != prev_stat)) begin
            // R4: status moved away from a comparison edge
            chk(1'b0, "R4 hold", int'({speed_up, slow_down}), int'(prev_stat));
        end
        prev_comp = comp_clk;
        prev_stat = {speed_up, slow_down};
        sync_in = toggling ? (((cyc + off) % ps) < ps / 2) : 1'b0;
        hist[cyc] = sync_in;
    endtask

    task automatic scenario(input bit en, input bit half, input bit csel, input int bdiv,
                            input bit tog, input int p, input int o, input int ncyc,
                            input int st, input bit lock);
        int lim;
        shift_en = en; half_rate = half; comp_sel = csel; baud_div = BAUD_W'(bdiv);
        toggling = tog; ps = p; off = o; settle = st; locking = lock;
        lim = csel ? ((bdiv < 2) ? 2 : bdiv) : C_DIV;
        base = A_DIV * B_DIV * lim;
        steps = half ? (lim + 1) / 2 : lim;
        rst_n = 1'b0; cyc = 0; have_prev = 1'b0; prev_comp = 1'b0; prev_stat = 2'b00;
        repeat (4) tick();
        // R1: reset state
        chk({clk_a, clk_b, comp_clk, speed_up, slow_down} == 5'b0, "R1 reset",
            int'({clk_a, clk_b, comp_clk, speed_up, slow_down}), 0);
        rst_n = 1'b1;
        repeat (ncyc) tick();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R2: free run, no transitions on the input
        scenario(1, 0, 0, 0, 0, 130, 0, 3000, 0, 0);
        // R7: stepping off, input toggling but ignored
        scenario(0, 0, 0, 0, 1, 130, 40, 3000, 0, 0);
        // R8 / R5: full-rate lock, slow and fast input
        scenario(1, 0, 0, 0, 1, 130, 40, 11000, 6000, 1);
        scenario(1, 0, 0, 0, 1, 126, 90, 11000, 6000, 1);
        // R8 / R5: half-rate lock, odd input period included
        scenario(1, 1, 0, 0, 1, 130, 20, 11000, 6000, 1);
        scenario(1, 1, 0, 0, 1, 127, 100, 11000, 6000, 1);
        // R6: programmable ratio 4 with lock
        scenario(1, 0, 1, 4, 1, 66, 30, 6000, 3000, 1);
        // R6: ratio 1 clamps to 2
        scenario(1, 0, 1, 1, 0, 66, 0, 1500, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule